// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by a fixed priority and presents the winner to a processor. Software configures it through a two-address byte port: a control address and an auxiliary address. A start word on the control address opens a short configuration sequence on the auxiliary address (vector base, then an optional cascade byte, then an optional mode byte). Once that sequence is complete, auxiliary writes load the mask, and control writes carry end-of-interrupt commands and the choice of which register a control read returns.

The request register records pending inputs, either on rising edges or by following input levels. The in-service register records requests the processor has taken and not yet retired. A request is eligible when it is unmasked and ranks above every in-service bit. The acknowledge cycle is a valid/ready handshake on the vector output. `vec_valid` rises whenever an eligible request exists. The processor accepts by holding `vec_ready` high in a cycle where `vec_valid` is high, and that cycle is the acknowledge. Back-pressure is unlimited: while `vec_ready` is low, nothing moves between registers. `vec_data` always names the current winner, so a higher request arriving before acceptance replaces the offered vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A control write with bit 4 set is the start word: it restarts configuration, sets the mask to 0xFF, clears the request and in-service registers, and makes control reads return the request register.
- R2: After the start word, auxiliary writes are taken in order as vector base, cascade byte, and mode byte. The cascade byte is skipped when start-word bit 1 is set. The mode byte is expected only when start-word bit 0 is set. `irq_out` stays low until the last expected word has been written.
- R3: The cascade byte written during configuration appears on `cascade_cfg`.
- R4: After configuration, an auxiliary write loads the mask, where a 1 bit blocks that input. An auxiliary read returns the mask.
- R5: With start-word bit 3 clear (edge mode), a rising edge on an input sets its request bit at the next clock edge. The bit stays set until that request is accepted.
- R6: With start-word bit 3 set (level mode), each request bit copies its input level, registered one clock later.
- R7: Priority is fixed, with input 0 highest. `irq_out` is high, combinationally, exactly when configuration is complete and some unmasked request bit lies below the lowest set in-service bit (or any unmasked bit, if in-service is empty).
- R8: `vec_valid` equals `irq_out`. In a cycle with `vec_valid` and `vec_ready` both high, the winning input moves into in-service, its edge request is cleared, and `vec_data` is the base with its low 3 bits replaced by the input number.
- R9: A control write of 0x20 (bits 4 and 3 clear) clears the lowest-numbered set in-service bit.
- R10: A control write of 0x60 plus n clears in-service bit n. Other command words with bits 4 and 3 clear leave in-service unchanged.
- R11: A control write with bit 4 clear and bit 3 set selects the status read. Bits [1:0] = 11 select in-service, 10 selects request, and other values keep the previous choice.
- R12: While `vec_valid` is high and `vec_ready` is low, the request and in-service registers keep their values and `vec_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_sel_aux | input | 1 | 0 selects the control address, 1 selects the auxiliary address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: status register (control) or mask (auxiliary) |
| irq_in | input | 8 | Interrupt request inputs |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | A vector is on offer |
| vec_ready | input | 1 | Processor accepts the vector (acknowledge) |
| vec_data | output | 8 | Vector of the current winning input |
| cascade_cfg | output | 8 | Cascade byte captured during configuration |

## Verification
The assertions assume that `vec_ready` is raised only as a deliberate acknowledge, and that end-of-interrupt commands arrive through register writes and never from any other path. The in-service hold property also assumes that no register write lands in a cycle that is exerting back-pressure. The stimulus keeps to these assumptions. Every write, request pulse and acknowledge occupies its own cycle, and the bench never raises `vec_ready` together with `reg_wr`. Inputs change only just after a clock edge, and the bench holds each edge-mode pulse low again before issuing the next one.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_BASE   = 3'd1,
    ST_CASC   = 3'd2,
    ST_MODE   = 3'd3,
    ST_READY  = 3'd4
  } cfg_state_t;

  localparam logic [2:0] CMD_EOI_ANY = 3'b001;
  localparam logic [2:0] CMD_EOI_SEL = 3'b011;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_aux,
  input  logic [DW-1:0]            wr_data,
  output logic                     cfg_ready,
  output logic                     level_mode,
  output logic [DW-$clog2(N_IN)-1:0] base_hi,
  output logic [DW-1:0]            casc_byte,
  output logic [N_IN-1:0]          mask,
  output logic                     sel_isr,
  output logic                     start_pulse,
  output logic                     eoi_any,
  output logic                     eoi_sel,
  output logic [$clog2(N_IN)-1:0]  eoi_lvl
);
  localparam int IDX_W = $clog2(N_IN);

  cfg_state_t state;
  logic       need_casc;
  logic       need_mode;
  logic       ctl_wr, aux_wr, cmd_wr, stat_wr;

  assign ctl_wr      = wr_en && !wr_aux;
  assign aux_wr      = wr_en && wr_aux;
  assign start_pulse = ctl_wr && wr_data[4];
  assign cmd_wr      = ctl_wr && !wr_data[4] && !wr_data[3];
  assign stat_wr     = ctl_wr && !wr_data[4] && wr_data[3];
  assign eoi_any     = cmd_wr && (wr_data[7:5] == CMD_EOI_ANY);
  assign eoi_sel     = cmd_wr && (wr_data[7:5] == CMD_EOI_SEL);
  assign eoi_lvl     = wr_data[IDX_W-1:0];
  assign cfg_ready   = (state == ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_UNINIT;
      need_casc  <= 1'b0;
      need_mode  <= 1'b0;
      level_mode <= 1'b0;
      base_hi    <= '0;
      casc_byte  <= '0;
      mask       <= '1;
      sel_isr    <= 1'b0;
    end else if (start_pulse) begin
      state      <= ST_BASE;
      need_casc  <= !wr_data[1];
      need_mode  <= wr_data[0];
      level_mode <= wr_data[3];
      mask       <= '1;
      sel_isr    <= 1'b0;
    end else begin
      if (stat_wr && wr_data[1]) sel_isr <= wr_data[0];
      if (aux_wr) begin
        case (state)
          ST_BASE: begin
            base_hi <= wr_data[DW-1:IDX_W];
            if (need_casc)      state <= ST_CASC;
            else if (need_mode) state <= ST_MODE;
            else                state <= ST_READY;
          end
          ST_CASC: begin
            casc_byte <= wr_data;
            state     <= need_mode ? ST_MODE : ST_READY;
          end
          ST_MODE:  state <= ST_READY;
          ST_READY: mask  <= wr_data[N_IN-1:0];
          default:  state <= state;
        endcase
      end
    end
  end

  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (mask == '1 && state != ST_READY && !sel_isr));
endmodule

// File: rtl/pic_req_regs.sv
module pic_req_regs #(
  parameter int N_IN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         irq_in,
  input  logic                    level_mode,
  input  logic                    clr_all,
  input  logic                    ack_fire,
  input  logic [N_IN-1:0]         ack_grant,
  input  logic                    eoi_any,
  input  logic                    eoi_sel,
  input  logic [$clog2(N_IN)-1:0] eoi_lvl,
  output logic [N_IN-1:0]         irr,
  output logic [N_IN-1:0]         isr
);
  logic [N_IN-1:0] prev_in;
  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] any_clr;
  logic [N_IN-1:0] sel_clr;
  logic [N_IN-1:0] take;

  assign rise    = irq_in & ~prev_in;
  assign take    = ack_fire ? ack_grant : '0;
  assign sel_clr = eoi_sel ? (N_IN'(1) << eoi_lvl) : '0;

  always_comb begin
    logic seen;
    seen    = 1'b0;
    any_clr = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (eoi_any && isr[i] && !seen) begin
        any_clr[i] = 1'b1;
        seen       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_in <= '0;
      irr     <= '0;
      isr     <= '0;
    end else begin
      prev_in <= irq_in;
      if (clr_all) begin
        irr <= '0;
        isr <= '0;
      end else begin
        if (level_mode) irr <= irq_in;
        else            irr <= (irr & ~take) | rise;
        isr <= (isr & ~any_clr & ~sel_clr) | take;
      end
    end
  end

  p_eoi_clears_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any && !ack_fire && !clr_all && isr != '0)
      |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N_IN = 8
) (
  input  logic                    enable,
  input  logic [N_IN-1:0]         irr,
  input  logic [N_IN-1:0]         isr,
  input  logic [N_IN-1:0]         mask,
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    any_req,
  output logic [N_IN-1:0]         grant,
  output logic [$clog2(N_IN)-1:0] grant_idx
);
  localparam int IDX_W = $clog2(N_IN);

  logic [N_IN-1:0] cand;

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      blocked = blocked | isr[i];
      cand[i] = enable && irr[i] && !mask[i] && !blocked;
    end
  end

  always_comb begin
    logic hit;
    hit       = 1'b0;
    grant     = '0;
    grant_idx = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (cand[i] && !hit) begin
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
        hit       = 1'b1;
      end
    end
  end

  assign any_req = |cand;

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_req == (grant != '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel_aux,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            irq_out,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [DW-1:0]   vec_data,
  output logic [DW-1:0]   cascade_cfg
);
  localparam int IDX_W = $clog2(N_IN);

  logic                 cfg_ready, level_mode, sel_isr, start_pulse;
  logic                 eoi_any, eoi_sel, any_req, ack_fire;
  logic [DW-IDX_W-1:0]  base_hi;
  logic [N_IN-1:0]      mask, irr_w, isr_w, grant;
  logic [IDX_W-1:0]     eoi_lvl, grant_idx;
  logic [DW-1:0]        status_w;

  pic_cfg_regs #(.N_IN(N_IN), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_aux(reg_sel_aux),
    .wr_data(reg_wdata), .cfg_ready(cfg_ready), .level_mode(level_mode),
    .base_hi(base_hi), .casc_byte(cascade_cfg), .mask(mask),
    .sel_isr(sel_isr), .start_pulse(start_pulse), .eoi_any(eoi_any),
    .eoi_sel(eoi_sel), .eoi_lvl(eoi_lvl)
  );

  pic_req_regs #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .clr_all(start_pulse), .ack_fire(ack_fire), .ack_grant(grant),
    .eoi_any(eoi_any), .eoi_sel(eoi_sel), .eoi_lvl(eoi_lvl),
    .irr(irr_w), .isr(isr_w)
  );

  pic_prio_pick #(.N_IN(N_IN)) u_pick (
    .enable(cfg_ready), .irr(irr_w), .isr(isr_w), .mask(mask),
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .grant(grant),
    .grant_idx(grant_idx)
  );

  assign irq_out   = any_req;
  assign vec_valid = any_req;
  assign ack_fire  = vec_valid && vec_ready;
  assign vec_data  = {base_hi, grant_idx};
  assign status_w  = DW'(sel_isr ? isr_w : irr_w);
  assign reg_rdata = reg_sel_aux ? DW'(mask) : status_w;

  p_quiet_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> !irq_out);

  p_ack_fills_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !reg_wr) |=> (isr_w != '0));

  p_isr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready && !reg_wr) |=> $stable(isr_w));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel_aux = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] irq_in = '0;
  logic       irq_out;
  logic       vec_valid;
  logic       vec_ready = 1'b0;
  logic [7:0] vec_data;
  logic [7:0] cascade_cfg;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_aux(reg_sel_aux),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .cascade_cfg(cascade_cfg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic aux, input logic [7:0] d);
    tick(); reg_wr = 1'b1; reg_sel_aux = aux; reg_wdata = d;
    tick(); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic aux, input logic [7:0] exp);
    tick(); reg_sel_aux = aux;
    @(negedge clk); chk(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk); chk(req, {7'd0, irq_out}, {7'd0, exp});
  endtask

  task automatic pulse(input int n);
    tick(); irq_in[n] = 1'b1;
    tick(); irq_in[n] = 1'b0;
  endtask

  // Driver: records the expected vector, then accepts one vector.
  task automatic ack(input logic [7:0] exp);
    exp_q.push_back(exp);
    tick(); vec_ready = 1'b1;
    tick(); vec_ready = 1'b0;
  endtask

  // Monitor: compares each accepted vector against the scoreboard (R8).
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (exp_q.size() == 0) chk("R8 unexpected vector", vec_data, 8'hxx);
      else chk("R8 vector", vec_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    irq_chk("R2 reset irq", 1'b0);
    rd_chk("R4 reset mask", 1'b1, 8'hFF);

    // Edge mode, cascade byte and mode byte expected.
    pulse(3);
    irq_chk("R2 no irq before config", 1'b0);
    wr(1'b0, 8'h11);
    rd_chk("R1 request cleared by start", 1'b0, 8'h00);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h04);
    chk("R3 cascade byte", cascade_cfg, 8'h04);
    wr(1'b0, 8'h0B);              // select in-service for later reads (R11)
    wr(1'b0, 8'h0A);              // back to request
    pulse(5);
    irq_chk("R2 still quiet before mode byte", 1'b0);
    wr(1'b1, 8'h01);
    irq_chk("R4 masked after config", 1'b0);
    rd_chk("R5 edge latched", 1'b0, 8'h20);
    wr(1'b1, 8'h00);
    irq_chk("R7 irq for unmasked", 1'b1);
    ack(8'h45);
    rd_chk("R8 request cleared on accept", 1'b0, 8'h00);
    wr(1'b0, 8'h0B);
    rd_chk("R11 in-service read", 1'b0, 8'h20);

    pulse(6);
    irq_chk("R7 lower priority blocked", 1'b0);
    pulse(2);
    irq_chk("R7 higher priority nests", 1'b1);
    ack(8'h42);
    rd_chk("R8 nested in-service", 1'b0, 8'h24);
    wr(1'b0, 8'h40);
    rd_chk("R10 other command ignored", 1'b0, 8'h24);
    wr(1'b0, 8'h20);
    rd_chk("R9 nonspecific clears lowest", 1'b0, 8'h20);
    irq_chk("R7 still blocked by bit 5", 1'b0);
    wr(1'b0, 8'h65);
    rd_chk("R10 specific clears bit 5", 1'b0, 8'h00);
    irq_chk("R7 pending 6 released", 1'b1);
    ack(8'h46);
    wr(1'b0, 8'h66);
    rd_chk("R10 specific clears bit 6", 1'b0, 8'h00);

    // Mask behaviour.
    wr(1'b1, 8'h02);
    rd_chk("R4 mask readback", 1'b1, 8'h02);
    pulse(1);
    irq_chk("R4 masked input silent", 1'b0);
    wr(1'b0, 8'h08);              // bits[1:0]=00 keep choice (in-service)
    rd_chk("R11 select unchanged", 1'b0, 8'h00);
    wr(1'b0, 8'h0A);
    rd_chk("R11 request read", 1'b0, 8'h02);
    wr(1'b1, 8'h00);
    irq_chk("R4 unmask releases", 1'b1);
    ack(8'h41);
    wr(1'b0, 8'h20);

    // Two requests at once, then back-pressure.
    tick(); irq_in = 8'h90;
    tick(); irq_in = 8'h00;
    ack(8'h44);
    wr(1'b0, 8'h20);
    repeat (5) tick();
    irq_chk("R12 valid held under back-pressure", 1'b1);
    rd_chk("R12 request held", 1'b0, 8'h80);
    ack(8'h47);
    wr(1'b0, 8'h20);
    irq_chk("R7 idle after retire", 1'b0);

    // Level mode, single (no cascade byte), no mode byte.
    wr(1'b0, 8'h1A);
    rd_chk("R1 start resets mask", 1'b1, 8'hFF);
    wr(1'b1, 8'h80);
    chk("R3 cascade kept when skipped", cascade_cfg, 8'h04);
    wr(1'b1, 8'h00);
    tick(); irq_in[0] = 1'b1;
    irq_chk("R6 level registered", 1'b0);
    irq_chk("R6 level seen", 1'b1);
    ack(8'h80);
    irq_chk("R7 blocked while in service", 1'b0);
    wr(1'b0, 8'h20);
    irq_chk("R6 level reasserts", 1'b1);
    tick(); irq_in[0] = 1'b0;
    tick();
    irq_chk("R6 level released", 1'b0);

    repeat (2) tick();
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R8 vectors never accepted: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule